// File: doc/BRIEF.md
# Two-Stage Operand Pipeline Sequencer

This block is the control sequencer for a two-stage operand execution pipeline. It receives one 16-bit operation word at a time from the instruction buffer. From that word it picks the instruction class and checks whether the opcode is legal. It then drives the per-cycle enables for the four stage functions: decode/address select, address generation, operand fetch and execute. It also drives the memory read and write strobes and an accept handshake back toward the fetch side.

The datapath is outside this block. The sequencer only decides which stage function runs in which cycle.

- A register-to-register operation takes a single issue cycle.
- A memory-source operation makes two passes through the same two stages.
- A store folds both passes into one cycle.
- A read-modify-write chains a load pass with a store pass.

An illegal word reserves no stage. Instead, it produces a one-cycle exception request carrying vector number 4.

The first-stage functions (decode/select and operand fetch) and the accept signal are combinational from the presented word and the internal step count. The second-stage functions (address generation, execute and memory write) and the exception request are registered. They therefore appear one cycle after the first-stage activity that caused them.

Top module: `op_pipe_seq`

## Requirements
- R1: After reset, with no valid word presented, every stage enable, both memory strobes, the accept signal and the exception request are low.
- R2: A word with bits [15:14] = 00 (register-to-register) enables operand fetch and is accepted in the cycle it is presented. Execute is enabled in the following cycle.
- R3: A word with bits [15:14] = 01 (memory source) enables decode/select in its first cycle, with no accept. In its second cycle it enables operand fetch, memory read, address generation and accept. Execute follows in the third cycle.
- R4: A word with bits [15:14] = 10 (store) enables decode/select and operand fetch together and is accepted in one cycle. In the next cycle, address generation, execute and memory write are all enabled.
- R5: A word with bits [15:14] = 11 (read-modify-write) runs three issue cycles and is accepted only in the third. The first two issue cycles form a load pass as in R3. The third is a store pass as in R4, and memory write is enabled in the cycle after it.
- R6: A word with bits [13:12] = 11 is illegal whatever its class. It is accepted in one cycle, enables no stage and no memory strobe, and raises the exception request for exactly the next cycle. The exception vector output is always 4.
- R7: A new word presented in the cycle right after an accept starts its own sequence at once, while the earlier word's second-stage activity completes in parallel.
- R8: If the valid signal drops before a multi-cycle word is accepted, or a reset occurs, the next word starts again from its first issue cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Operation word is presented |
| ins_word | input | 16 | Operation word (class in [15:14], illegal marker in [13:12]) |
| ins_accept | output | 1 | Word consumed this cycle |
| en_ds | output | 1 | Decode / address-component select enable |
| en_oc | output | 1 | Operand fetch enable |
| en_ag | output | 1 | Address generation enable |
| en_ex | output | 1 | Execute enable |
| mem_rd | output | 1 | Memory operand read request |
| mem_wr | output | 1 | Memory write request |
| exc_req | output | 1 | Illegal-opcode exception request |
| exc_vector | output | 8 | Exception vector number |

## Verification
Each of the four classes is presented alone. The resulting cycle-by-cycle enable pattern distinguishes a single pass, two passes, a collapsed store and a chained load-plus-store. Illegal words in two different classes show that the legality check overrides the class. A register operation followed directly by a store shows that a new issue overlaps the previous second stage without a bubble. Two further cases cover restarting from the first issue cycle: a memory-source word withdrawn mid-sequence, and a read-modify-write cut off by reset.

// File: rtl/op_pipe_seq.sv
module op_pipe_seq #(
  parameter int          WORD_W  = 16,
  parameter logic [7:0]  EXC_VEC = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [WORD_W-1:0] ins_word,
  output logic              ins_accept,
  output logic              en_ds,
  output logic              en_oc,
  output logic              en_ag,
  output logic              en_ex,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              exc_req,
  output logic [7:0]        exc_vector
);
  localparam logic [1:0] C_RR  = 2'b00;
  localparam logic [1:0] C_LD  = 2'b01;
  localparam logic [1:0] C_ST  = 2'b10;
  localparam logic [1:0] C_RMW = 2'b11;

  logic [1:0] cls, step, last_step;
  logic       illegal, go, load_pass, store_pass;
  logic       ag_q, ex_q, wr_q, exc_q;

  assign cls     = ins_word[WORD_W-1 -: 2];
  assign illegal = &ins_word[WORD_W-3 -: 2];
  assign go      = ins_valid && !illegal;

  always_comb begin
    case (cls)
      C_LD:    last_step = 2'd1;
      C_RMW:   last_step = 2'd2;
      default: last_step = 2'd0;
    endcase
  end

  assign load_pass  = (cls == C_LD) || (cls == C_RMW && step != 2'd2);
  assign store_pass = (cls == C_ST) || (cls == C_RMW && step == 2'd2);

  assign en_ds  = go && ((load_pass && step == 2'd0) || store_pass);
  assign en_oc  = go && ((cls == C_RR) || (load_pass && step == 2'd1) || store_pass);
  assign mem_rd = go && load_pass && step == 2'd1;
  assign ins_accept = ins_valid && (illegal || step == last_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= '0;
      ag_q  <= 1'b0;
      ex_q  <= 1'b0;
      wr_q  <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      step  <= (!ins_valid || ins_accept) ? 2'd0 : step + 2'd1;
      ag_q  <= en_ds;
      ex_q  <= en_oc;
      wr_q  <= go && store_pass;
      exc_q <= ins_valid && illegal;
    end
  end

  assign en_ag      = ag_q;
  assign en_ex      = ex_q;
  assign mem_wr     = wr_q;
  assign exc_req    = exc_q;
  assign exc_vector = EXC_VEC;

  assert_ex_follows_oc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_oc |=> en_ex);
  assert_ag_follows_ds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_ds |=> en_ag);
  assert_rd_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> en_oc && !en_ds);
  assert_store_collapse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> en_ag && en_ex);
  assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !en_ex && !en_ag && !mem_wr);
  assert_exc_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_req) |-> $past(ins_accept));
endmodule

// File: tb/test_op_pipe_seq.sv
module test_op_pipe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [15:0] ins_word = '0;
  logic        ins_accept, en_ds, en_oc, en_ag, en_ex, mem_rd, mem_wr, exc_req;
  logic [7:0]  exc_vector;
  int checks = 0, errors = 0;

  localparam logic [15:0] W_RR  = 16'h0123;
  localparam logic [15:0] W_LD  = 16'h4000;
  localparam logic [15:0] W_ST  = 16'h8000;
  localparam logic [15:0] W_RMW = 16'hC000;
  localparam logic [15:0] W_IL0 = 16'h3000;
  localparam logic [15:0] W_IL3 = 16'hF000;

  always #4 clk = ~clk;

  op_pipe_seq i_op_pipe_seq (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_accept(ins_accept), .en_ds(en_ds), .en_oc(en_oc), .en_ag(en_ag),
    .en_ex(en_ex), .mem_rd(mem_rd), .mem_wr(mem_wr), .exc_req(exc_req),
    .exc_vector(exc_vector)
  );

  // vector order: {ds, oc, rd, ag, ex, wr, accept, exc}
  task automatic step_chk(input logic v, input logic [15:0] w,
                          input logic [7:0] exp, input string tag);
    logic [7:0] act;
    @(posedge clk); #1;
    ins_valid = v; ins_word = w;
    @(negedge clk);
    act = {en_ds, en_oc, mem_rd, en_ag, en_ex, mem_wr, ins_accept, exc_req};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    step_chk(1'b0, '0, 8'b00000000, "R1 reset idle");
  endtask

  task automatic t_regreg;
    step_chk(1'b1, W_RR, 8'b01000010, "R2 fetch+accept");
    step_chk(1'b0, '0,   8'b00001000, "R2 execute");
  endtask

  task automatic t_load;
    step_chk(1'b1, W_LD, 8'b10000000, "R3 select pass");
    step_chk(1'b1, W_LD, 8'b01110010, "R3 fetch pass");
    step_chk(1'b0, '0,   8'b00001000, "R3 execute");
  endtask

  task automatic t_store;
    step_chk(1'b1, W_ST, 8'b11000010, "R4 collapsed issue");
    step_chk(1'b0, '0,   8'b00011100, "R4 gen+exec+write");
  endtask

  task automatic t_rmw;
    step_chk(1'b1, W_RMW, 8'b10000000, "R5 load select");
    step_chk(1'b1, W_RMW, 8'b01110000, "R5 load fetch");
    step_chk(1'b1, W_RMW, 8'b11001010, "R5 store pass");
    step_chk(1'b0, '0,    8'b00011100, "R5 write");
  endtask

  task automatic t_illegal(input logic [15:0] w);
    step_chk(1'b1, w, 8'b00000010, "R6 illegal accept");
    step_chk(1'b0, '0, 8'b00000001, "R6 exception");
    step_chk(1'b0, '0, 8'b00000000, "R6 one cycle only");
    checks++;
    if (exc_vector !== 8'd4) begin
      errors++;
      $display("FAIL R6 vector: got %0d expected 4", exc_vector);
    end
  endtask

  task automatic t_back_to_back;
    step_chk(1'b1, W_RR, 8'b01000010, "R7 first issue");
    step_chk(1'b1, W_ST, 8'b11001010, "R7 second issue overlapped");
    step_chk(1'b0, '0,   8'b00011100, "R7 second completes");
  endtask

  task automatic t_restart;
    step_chk(1'b1, W_LD, 8'b10000000, "R8 first select");
    step_chk(1'b0, '0,   8'b00010000, "R8 withdrawn");
    step_chk(1'b1, W_LD, 8'b10000000, "R8 restart select");
    step_chk(1'b1, W_LD, 8'b01110010, "R8 restart fetch");
    step_chk(1'b0, '0,   8'b00001000, "R8 drain");
    step_chk(1'b1, W_RMW, 8'b10000000, "R8 rmw before reset");
    @(posedge clk); #1; ins_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    step_chk(1'b1, W_RMW, 8'b10000000, "R8 rmw restart after reset");
    step_chk(1'b0, '0,    8'b00010000, "R8 drain after reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regreg();
    t_load();
    t_store();
    t_rmw();
    t_illegal(W_IL0);
    t_illegal(W_IL3);
    t_back_to_back();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule